// File: doc/BRIEF.md
# Double-Buffered PWM Generator

This block is a single-channel pulse-width modulator. A counter, slowed by a power-of-two prescaler, runs up to a modulus value and back down again. A comparison against a duty value sets the output high or low. The counter can count edge-aligned (up, then wrap) or center-aligned (up, then down).

Software programs the block through a small synchronous register port. Writes to the divisor, modulus and duty registers land only in shadow registers. When software arms a load-OK flag, the three shadow values are captured together into a buffer stage. The running generator then takes the buffered set at its next load boundary and clears the flag on its own.

To arm the flag, software must read the control register while the flag is 0 and then write 1 to it. This protects the buffered set against a stray write. A run bit starts and stops the counter. When the block is stopped, the output enable drops unless an override bit keeps the pin driven. Every load boundary pulses a reload strobe and sets a sticky interrupt request, whether or not a reload was pending.

Top module: `pwm_dbuf`

## Requirements
- R1: After reset the control register reads 0 (run, load-OK, center, override and interrupt all clear), and pwm_o, pwm_oe_o, reload_o and irq_o are all 0.
- R2: Writes to the divisor (address 1), modulus (address 2) or duty (address 3) registers do not change the output waveform. The active values change only at a load taken while load-OK is 1.
- R3: Load-OK (control bit 1, control register at address 0) becomes 1 only when 1 is written to it after a read of the control register that returned load-OK = 0. No other control write may come between the read and the write. A write of 1 without such a read is ignored.
- R4: Load-OK returns to 0 by itself after the load it requested. Writing control with bit 1 = 0 clears it and cancels the pending reload.
- R5: At the moment load-OK is set, the divisor, modulus and duty shadows are captured into the buffer together. Shadow writes made after that do not reach the reload in progress.
- R6: With run (control bit 0) = 0, the counter is held at zero, pwm_o is 0, reload_o stays 0, and pwm_oe_o equals the override bit (control bit 3). A load-OK set while stopped loads on the next cycle.
- R7: reload_o pulses for one cycle at each load boundary. irq_o (control bit 4 on read) is set by every boundary, even when load-OK is 0. It is cleared by writing control with bit 4 = 1.
- R8: In edge-aligned mode (control bit 2 = 0), the period is (modulus+1) counter steps, and the output is high while the counter is below duty.
- R9: In center-aligned mode (control bit 2 = 1), the period is 2*modulus steps. For 0 < duty < modulus the output is high for 2*duty-1 steps.
- R10: A duty of 0 gives a constant low output. A duty ≥ modulus gives a constant high output in both modes.
- R11: A divisor value p makes each counter step last 2^p clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (arms load-OK) |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| pwm_o | output | 1 | PWM output level |
| pwm_oe_o | output | 1 | Output driver enable |
| reload_o | output | 1 | One-cycle load boundary strobe |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The assertions check the following on every cycle:
- load-OK rises only on a control write and falls after the boundary that consumes it;
- the active duty changes only in a load cycle;
- a stopped counter is held at zero;
- the counter never exceeds the active modulus;
- a zero duty keeps the output low;
- each boundary leaves the interrupt raised.

Only the directed scenarios can show what happens over whole periods:
- the period and high-time arithmetic of both counting modes and of the prescaler;
- that a shadow write after arming stays out of the reload;
- that a write of 1 without the read is ignored;
- that a cleared flag cancels a reload.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;
  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_PRESC = 1;
  localparam int unsigned ADDR_MOD   = 2;
  localparam int unsigned ADDR_DUTY  = 3;

  localparam int unsigned B_RUN    = 0;
  localparam int unsigned B_LDOK   = 1;
  localparam int unsigned B_CENTER = 2;
  localparam int unsigned B_OVR    = 3;
  localparam int unsigned B_IRQ    = 4;

  typedef struct packed {
    logic ovr;
    logic center;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned PS_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              load_i,
  input  logic              bound_i,
  output ctrl_t             ctrl_o,
  output logic              ldok_o,
  output logic              irq_o,
  output logic [PS_W-1:0]   presc_b_o,
  output logic [CNT_W-1:0]  mod_b_o,
  output logic [CNT_W-1:0]  duty_b_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic sel_ctrl, wr_ctrl, arm_q;
  logic [PS_W-1:0]  presc_s;
  logic [CNT_W-1:0] mod_s, duty_s;

  assign sel_ctrl = (addr_i == ADDR_W'(ADDR_CTRL));
  assign wr_ctrl  = wr_i && sel_ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '0;
      ldok_o    <= 1'b0;
      arm_q     <= 1'b0;
      irq_o     <= 1'b0;
      presc_s   <= '0;
      mod_s     <= '0;
      duty_s    <= '0;
      presc_b_o <= '0;
      mod_b_o   <= '0;
      duty_b_o  <= '0;
    end else begin
      if (wr_i && addr_i == ADDR_W'(ADDR_PRESC)) presc_s <= wdata_i[PS_W-1:0];
      if (wr_i && addr_i == ADDR_W'(ADDR_MOD))   mod_s   <= wdata_i[CNT_W-1:0];
      if (wr_i && addr_i == ADDR_W'(ADDR_DUTY))  duty_s  <= wdata_i[CNT_W-1:0];

      if (wr_ctrl) begin
        ctrl_o.run    <= wdata_i[B_RUN];
        ctrl_o.center <= wdata_i[B_CENTER];
        ctrl_o.ovr    <= wdata_i[B_OVR];
      end

      // arming: a read that sees load-OK low, consumed by the next control write
      if (wr_ctrl)                     arm_q <= 1'b0;
      else if (rd_i && sel_ctrl && !ldok_o) arm_q <= 1'b1;

      if (wr_ctrl && wdata_i[B_LDOK]) begin
        if (arm_q) begin
          ldok_o    <= 1'b1;
          presc_b_o <= presc_s;
          mod_b_o   <= mod_s;
          duty_b_o  <= duty_s;
        end else if (load_i) begin
          ldok_o <= 1'b0;
        end
      end else if (wr_ctrl || load_i) begin
        ldok_o <= 1'b0;
      end

      if (bound_i)                        irq_o <= 1'b1;
      else if (wr_ctrl && wdata_i[B_IRQ]) irq_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) begin
      rdata_o[B_RUN]    = ctrl_o.run;
      rdata_o[B_LDOK]   = ldok_o;
      rdata_o[B_CENTER] = ctrl_o.center;
      rdata_o[B_OVR]    = ctrl_o.ovr;
      rdata_o[B_IRQ]    = irq_o;
    end else if (addr_i == ADDR_W'(ADDR_PRESC)) begin
      rdata_o[PS_W-1:0] = presc_s;
    end else if (addr_i == ADDR_W'(ADDR_MOD)) begin
      rdata_o[CNT_W-1:0] = mod_s;
    end else if (addr_i == ADDR_W'(ADDR_DUTY)) begin
      rdata_o[CNT_W-1:0] = duty_s;
    end
  end
endmodule

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PS_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             center_i,
  input  logic             load_i,
  input  logic [PS_W-1:0]  presc_b_i,
  input  logic [CNT_W-1:0] mod_b_i,
  input  logic [CNT_W-1:0] duty_b_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] mod_a_o,
  output logic [CNT_W-1:0] duty_a_o,
  output logic             bound_o
);
  localparam int unsigned PRE_W = (1 << PS_W) - 1;

  logic [PS_W-1:0]  presc_a;
  logic [PRE_W-1:0] pre_cnt, pre_lim;
  logic             dir_dn, tick, at_top, at_low;

  assign pre_lim = ~({PRE_W{1'b1}} << presc_a);
  assign tick    = run_i && (pre_cnt >= pre_lim);
  assign at_top  = (cnt_o >= mod_a_o);
  assign at_low  = (cnt_o <= CNT_W'(1));

  always_comb begin
    if (center_i) bound_o = tick && (dir_dn || at_top) && at_low;
    else          bound_o = tick && at_top;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_a  <= '0;
      mod_a_o  <= '0;
      duty_a_o <= '0;
    end else if (load_i) begin
      presc_a  <= presc_b_i;
      mod_a_o  <= mod_b_i;
      duty_a_o <= duty_b_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt <= '0;
      cnt_o   <= '0;
      dir_dn  <= 1'b0;
    end else if (!run_i) begin
      pre_cnt <= '0;
      cnt_o   <= '0;
      dir_dn  <= 1'b0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + PRE_W'(1);
      if (tick) begin
        if (bound_o) begin
          cnt_o  <= '0;
          dir_dn <= 1'b0;
        end else if (!center_i) begin
          cnt_o  <= cnt_o + CNT_W'(1);
          dir_dn <= 1'b0;
        end else if (dir_dn || at_top) begin
          cnt_o  <= cnt_o - CNT_W'(1);
          dir_dn <= 1'b1;
        end else begin
          cnt_o <= cnt_o + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pwm_dbuf.sv
module pwm_dbuf
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned PS_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pwm_o,
  output logic              pwm_oe_o,
  output logic              reload_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic             ldok, load, bound;
  logic [PS_W-1:0]  presc_b;
  logic [CNT_W-1:0] mod_b, duty_b, cnt, mod_a, duty_a;

  assign load = ldok && (bound || !ctrl.run);

  pwm_dbuf_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PS_W(PS_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .load_i(load), .bound_i(bound),
    .ctrl_o(ctrl), .ldok_o(ldok), .irq_o(irq_o),
    .presc_b_o(presc_b), .mod_b_o(mod_b), .duty_b_o(duty_b),
    .rdata_o(rdata_o)
  );

  pwm_dbuf_timer #(.CNT_W(CNT_W), .PS_W(PS_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(ctrl.run), .center_i(ctrl.center),
    .load_i(load), .presc_b_i(presc_b), .mod_b_i(mod_b), .duty_b_i(duty_b),
    .cnt_o(cnt), .mod_a_o(mod_a), .duty_a_o(duty_a), .bound_o(bound)
  );

  // duty >= modulus saturates high; zero duty is always low
  assign pwm_o    = ctrl.run && (duty_a != '0) && ((duty_a >= mod_a) || (cnt < duty_a));
  assign pwm_oe_o = ctrl.run || ctrl.ovr;
  assign reload_o = bound;
endmodule

// File: rtl/pwm_dbuf_chk.sv
module pwm_dbuf_chk
  import pwm_dbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              run_i,
  input logic              ldok_i,
  input logic              load_i,
  input logic              bound_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  mod_a_i,
  input logic [CNT_W-1:0]  duty_a_i,
  input logic              pwm_o,
  input logic              irq_o
);
  logic wr_ctrl;
  assign wr_ctrl = wr_i && (addr_i == ADDR_W'(ADDR_CTRL));

  AST_LDOK_SET_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ldok_i) |-> $past(wr_ctrl && wdata_i[B_LDOK])); // R3
  AST_LDOK_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldok_i && bound_i && !wr_ctrl) |=> !ldok_i); // R4
  AST_DUTY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(duty_a_i) |-> $past(load_i)); // R2
  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_i == '0)); // R6
  AST_IRQ_ON_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound_i |=> irq_o); // R7
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_i <= mod_a_i)); // R8
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_a_i == '0) |-> !pwm_o); // R10
endmodule

bind pwm_dbuf pwm_dbuf_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .run_i(ctrl.run), .ldok_i(ldok), .load_i(load), .bound_i(bound), .cnt_i(cnt),
  .mod_a_i(mod_a), .duty_a_i(duty_a), .pwm_o(pwm_o), .irq_o(irq_o)
);

// File: tb/sim_pwm_dbuf.sv
module sim_pwm_dbuf;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;
  localparam logic [15:0] RUN = 16'h1, LDOK = 16'h2, CTR = 16'h4, OVR = 16'h8, IRQC = 16'h10;

  logic clk = 1'b0, rst_ni = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0, rdata_o;
  logic pwm_o, pwm_oe_o, reload_o, irq_o;
  int vectors = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  pwm_dbuf u0 (.clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o),
    .reload_o(reload_o), .irq_o(irq_o));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R8 watchdog act=%0d exp<=%0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); wr_i = 1'b1; addr_i = ADDR_W'(a); wdata_i = d;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk); rd_i = 1'b1; addr_i = ADDR_W'(a); #1 d = rdata_o;
    @(negedge clk); rd_i = 1'b0;
  endtask

  task automatic wait_reload();
    @(negedge clk);
    while (!reload_o) @(negedge clk);
  endtask

  task automatic measure(input string req, input int eper, input int ehi);
    int per = 0, hi = 0;
    wait_reload();
    do begin
      @(negedge clk); per++;
      if (pwm_o) hi++;
    end while (!reload_o);
    chk({req, " period"}, per, eper);
    chk({req, " high"}, hi, ehi);
  endtask

  task automatic arm_load(input int p, input int m, input int d, input logic [15:0] c);
    logic [15:0] v;
    wr(1, 16'(p)); wr(2, 16'(m)); wr(3, 16'(d));
    rd(0, v);
    wr(0, c | LDOK);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(0, v);
    chk("R1 ctrl", int'(v), 0);
    chk("R1 pwm", int'(pwm_o), 0);
    chk("R1 oe", int'(pwm_oe_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 reload", int'(reload_o), 0);
  endtask

  task automatic t_stopped_load();
    logic [15:0] v;
    arm_load(0, 49, 20, 16'h0);
    @(negedge clk);
    rd(0, v);
    chk("R6 stopped load clears ldok", int'(v[1]), 0);
    chk("R6 stopped oe", int'(pwm_oe_o), 0);
    wr(0, OVR);
    chk("R6 override oe", int'(pwm_oe_o), 1);
    chk("R6 override pwm low", int'(pwm_o), 0);
    wr(0, RUN);
    measure("R8 edge 49/20", 50, 20);
  endtask

  task automatic t_no_handshake();
    logic [15:0] v;
    wr(3, 16'd30);
    wr(0, RUN | LDOK);
    rd(0, v);
    chk("R3 ldok ignored without read", int'(v[1]), 0);
    measure("R3 duty unchanged", 50, 20);
  endtask

  task automatic t_handshake();
    logic [15:0] v;
    wait_reload();
    rd(0, v);
    wr(0, RUN | LDOK);
    rd(0, v);
    chk("R3 ldok set after read", int'(v[1]), 1);
    wr(3, 16'd10);
    chk("R2 no change before boundary", int'(pwm_o), 1);
    measure("R5 buffered duty 30", 50, 30);
    rd(0, v);
    chk("R4 ldok self clear", int'(v[1]), 0);
    measure("R2 late shadow not loaded", 50, 30);
  endtask

  task automatic t_cancel();
    logic [15:0] v;
    wait_reload();
    rd(0, v);
    wr(0, RUN | LDOK);
    wr(0, RUN);
    rd(0, v);
    chk("R4 manual clear", int'(v[1]), 0);
    measure("R4 cancelled reload", 50, 30);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    wait_reload();
    wr(0, RUN | IRQC);
    chk("R7 irq cleared", int'(irq_o), 0);
    wait_reload();
    @(negedge clk);
    chk("R7 irq on boundary with ldok 0", int'(irq_o), 1);
    rd(0, v);
    chk("R7 irq bit readable", int'(v[4]), 1);
  endtask

  task automatic t_center();
    wait_reload();
    arm_load(0, 20, 8, RUN | CTR);
    measure("R9 center 20/8", 40, 15);
    measure("R9 center repeat", 40, 15);
  endtask

  task automatic t_presc();
    wait_reload();
    arm_load(2, 9, 3, RUN);
    measure("R11 prescale", 40, 12);
    measure("R11 prescale repeat", 40, 12);
  endtask

  task automatic t_limits();
    arm_load(0, 9, 0, RUN);
    measure("R10 zero duty", 10, 0);
    measure("R10 zero duty repeat", 10, 0);
    arm_load(0, 9, 9, RUN);
    measure("R10 duty eq mod", 10, 10);
    measure("R10 duty eq mod repeat", 10, 10);
    arm_load(0, 9, 200, RUN | CTR);
    measure("R10 center duty gt mod", 18, 18);
    measure("R10 center repeat", 18, 18);
  endtask

  task automatic t_stop();
    int n = 0;
    wr(0, 16'h0);
    chk("R6 stop pwm", int'(pwm_o), 0);
    chk("R6 stop oe", int'(pwm_oe_o), 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (reload_o) n++;
    end
    chk("R6 no reloads when stopped", n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_stopped_load();
    t_no_handshake();
    t_handshake();
    t_cancel();
    t_irq();
    t_center();
    t_presc();
    t_limits();
    t_stop();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule